// File: doc/BRIEF.md
# Converter Sample Demultiplexer

This block sits behind a high-speed converter and arranges its output samples for slower downstream logic. One sample arrives on every system clock edge, together with an overrange flag. The block places samples on two parallel output words, a primary word and an auxiliary word, and it drives a data-ready strobe that downstream logic uses to capture them. Samples are unsigned offset-binary codes: 0x00 is the most negative input, 0x80 is mid-scale and 0xFF is the most positive.

Two static control inputs pick one of three modes. In single mode every sample goes straight to the primary word. In pair mode two consecutive samples leave together: the older one on the auxiliary word and the newer one on the primary word. In decimate mode every second sample is dropped and the kept samples are then paired in the same way. A synchronous reset restarts the output phase. A sync output marks the first output period after reset, so that several devices sharing one reset can line up their output words.

All signals are single-ended and synchronous to `clk`. In single mode the output period is one clock cycle, so the data-ready output is held high and downstream logic captures on every clock edge.

Top module: `sample_demux`

## Requirements
- R1: `split_en` low selects single mode (output period N=1). `split_en` high with `drop_sel` low selects pair mode (N=2). `split_en` high with `drop_sel` high selects decimate mode (N=4).
- R2: While `rst_n` is low at a clock edge, the next state is: `prim_out` and `aux_out` at mid-scale 0x80, `ovr_out` 0, `drdy_out` 0 and `sync_out` 1.
- R3: In single mode, the sample present at edge k appears on `prim_out` immediately after edge k, and `drdy_out` is 1 after every edge.
- R4: In single mode, `aux_out` keeps its value; samples do not reach it.
- R5: In pair mode, counting edges from k=0 at the first edge after reset release, an update happens at every odd k. After it, `prim_out` holds sample k and `aux_out` holds sample k-1. `drdy_out` is 1 exactly after odd edges.
- R6: In decimate mode an update happens at edges with k mod 4 = 2. After it, `prim_out` holds sample k and `aux_out` holds sample k-2, so samples at odd k are dropped. `drdy_out` is 1 after edges with k mod 4 equal to 2 or 3.
- R7: `prim_out` changes only in a cycle where `drdy_out` has just risen, or on any cycle in single mode.
- R8: `ovr_out` is the overrange flag that came in with the sample currently shown on `prim_out`.
- R9: `sync_out` stays 1 from reset until the first update after release. It falls on that same edge, at k = N/2.
- R10: A reset given in the middle of an output period restarts the phase, so the first update after release again occurs at k = N/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_in | input | 8 | Offset-binary sample, one per clock |
| ovr_in | input | 1 | Overrange flag of `smp_in` |
| split_en | input | 1 | High enables two-word output (pair or decimate) |
| drop_sel | input | 1 | With `split_en` high: high selects decimate mode |
| prim_out | output | 8 | Primary word, newer sample |
| aux_out | output | 8 | Auxiliary word, older sample |
| ovr_out | output | 1 | Overrange flag of the sample on `prim_out` |
| drdy_out | output | 1 | Data-ready strobe; the words change as it rises |
| sync_out | output | 1 | High during the first output period after reset |

## Verification
On every cycle the assertions check four things. The phase counter stays inside the current mode's period. The primary word moves only as the data-ready strobe rises, or in single mode. The auxiliary word is frozen in single mode. The sync output falls only while data-ready is high. Which sample lands on which word, the dropping of every second sample in decimate mode, the overrange pairing and the restart of the phase after a mid-period reset can only be seen in the bench sweeps, which compare every cycle against sample indices computed from the edge count.

// File: rtl/sdm_pkg.sv
// Shared types and mode arithmetic for the sample demultiplexer.
// Assumes at most four clock cycles per output period.
package sdm_pkg;

    localparam int PH_W = 2;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_PAIR   = 2'd1,
        MODE_DECIM  = 2'd2
    } sdm_mode_e;

    // Last phase value of the output period (N-1).
    function automatic logic [PH_W-1:0] ph_last(input sdm_mode_e m);
        case (m)
            MODE_PAIR:  ph_last = 2'd1;
            MODE_DECIM: ph_last = 2'd3;
            default:    ph_last = 2'd0;
        endcase
    endfunction

    // Phase at which the words update (N/2).
    function automatic logic [PH_W-1:0] ph_upd(input sdm_mode_e m);
        case (m)
            MODE_PAIR:  ph_upd = 2'd1;
            MODE_DECIM: ph_upd = 2'd2;
            default:    ph_upd = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdm_mode_dec.sv
// Decodes the two static control pins into an operating mode.
// Assumes the pins are static, or change only while the block is in reset.
module sdm_mode_dec
    import sdm_pkg::*;
(
    input  logic      split_en,
    input  logic      drop_sel,
    output sdm_mode_e mode,
    output logic      two_word
);

    // Mode select: the enable pin picks the family, the select pin picks within it.
    always_comb begin
        if (!split_en)     mode = MODE_SINGLE;
        else if (drop_sel) mode = MODE_DECIM;
        else               mode = MODE_PAIR;
        two_word = split_en;
    end

endmodule

// File: rtl/sdm_phase.sv
// Phase counter for the output period. It produces the stash and update
// enables and the registered data-ready strobe.
// Assumes a synchronous active-low reset that returns the phase to zero.
module sdm_phase
    import sdm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  sdm_mode_e       mode,
    output logic [PH_W-1:0] ph,
    output logic            stash_en,
    output logic            upd_en,
    output logic            drdy
);

    logic [PH_W-1:0] last_c;
    logic [PH_W-1:0] upd_c;

    // Mode-dependent period limits.
    always_comb begin
        last_c   = ph_last(mode);
        upd_c    = ph_upd(mode);
        stash_en = (ph == '0);
        upd_en   = (ph == upd_c);
    end

    // Count the phase, wrap at the end of the period, and register the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= '0;
            drdy <= 1'b0;
        end else begin
            ph   <= (ph >= last_c) ? '0 : ph + 1'b1;
            drdy <= (ph >= upd_c);
        end
    end

    // R1
    ph_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode) |-> (ph <= ph_last(mode)));

endmodule

// File: rtl/sdm_ports.sv
// Output word registers: the stash for the older sample, the primary and
// auxiliary words, and the overrange flag.
// Assumes offset-binary samples; the reset value is the mid-scale code.
module sdm_ports #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  logic         ovr,
    input  logic         two_word,
    input  logic         stash_en,
    input  logic         upd_en,
    output logic [W-1:0] prim,
    output logic [W-1:0] aux,
    output logic         ovr_q
);

    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    logic [W-1:0] stash;

    // Hold the older sample of a pair until the update edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    stash <= MID;
        else if (stash_en && two_word) stash <= smp;
    end

    // Load both words together on the update edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim  <= MID;
            aux   <= MID;
            ovr_q <= 1'b0;
        end else if (upd_en) begin
            prim  <= smp;
            ovr_q <= ovr;
            if (two_word) aux <= stash;
        end
    end

    // R4
    aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !two_word |=> $stable(aux));

endmodule

// File: rtl/sample_demux.sv
// Top of the converter sample demultiplexer. It wires the mode decode, the
// phase counter and the word registers together and drives the sync output.
// Assumes one sample per clock and static mode pins.
module sample_demux
    import sdm_pkg::*;
#(
    parameter int SMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             ovr_in,
    input  logic             split_en,
    input  logic             drop_sel,
    output logic [SMP_W-1:0] prim_out,
    output logic [SMP_W-1:0] aux_out,
    output logic             ovr_out,
    output logic             drdy_out,
    output logic             sync_out
);

    sdm_mode_e       mode;
    logic            two_word;
    logic [PH_W-1:0] ph;
    logic            stash_en;
    logic            upd_en;
    logic            sync_q;

    sdm_mode_dec u_dec (
        .split_en (split_en),
        .drop_sel (drop_sel),
        .mode     (mode),
        .two_word (two_word)
    );

    sdm_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .ph       (ph),
        .stash_en (stash_en),
        .upd_en   (upd_en),
        .drdy     (drdy_out)
    );

    sdm_ports #(.W(SMP_W)) u_ports (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (smp_in),
        .ovr      (ovr_in),
        .two_word (two_word),
        .stash_en (stash_en),
        .upd_en   (upd_en),
        .prim     (prim_out),
        .aux      (aux_out),
        .ovr_q    (ovr_out)
    );

    // Sync flag: set by reset, cleared by the first update after release.
    always_ff @(posedge clk) begin
        if (!rst_n)      sync_q <= 1'b1;
        else if (upd_en) sync_q <= 1'b0;
    end
    assign sync_out = sync_q;

    // R7
    prim_on_drdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prim_out) |-> (drdy_out && (!$past(drdy_out) || mode == MODE_SINGLE)));

    // R9
    sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_out) |-> drdy_out);

endmodule

// File: tb/sim_sample_demux.sv
module sim_sample_demux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] smp_in = 8'h00;
    logic       ovr_in = 1'b0;
    logic       split_en = 1'b0;
    logic       drop_sel = 1'b0;
    logic [7:0] prim_out;
    logic [7:0] aux_out;
    logic       ovr_out;
    logic       drdy_out;
    logic       sync_out;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sample_demux u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_in   (smp_in),
        .ovr_in   (ovr_in),
        .split_en (split_en),
        .drop_sel (drop_sel),
        .prim_out (prim_out),
        .aux_out  (aux_out),
        .ovr_out  (ovr_out),
        .drdy_out (drdy_out),
        .sync_out (sync_out)
    );

    function automatic logic [7:0] smp_of(input int k, input int seed);
        return 8'((k * 53 + seed * 17 + 5) & 255);
    endfunction

    function automatic logic ovr_of(input int k, input int seed);
        logic [7:0] s;
        s = smp_of(k, seed);
        return (s >= 8'hF0) || (s < 8'h10) || s[2];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reset, then run `cycles` edges in the mode given by (en, sel), checking each edge.
    task automatic run_mode(input logic en, input logic sel, input int n, input int cycles,
                            input int seed, input string tag);
        int h;
        logic [7:0] ep, ea;
        logic eo;
        h = n / 2;
        @(negedge clk);
        rst_n = 1'b0;
        split_en = en;
        drop_sel = sel;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk({tag, " R2 prim"}, prim_out, 8'h80);
        chk({tag, " R2 aux"}, aux_out, 8'h80);
        chk({tag, " R2 ovr"}, ovr_out, 0);
        chk({tag, " R2 drdy"}, drdy_out, 0);
        chk({tag, " R2 sync"}, sync_out, 1);
        ep = 8'h80; ea = 8'h80; eo = 1'b0;
        rst_n = 1'b1;
        smp_in = smp_of(0, seed);
        ovr_in = ovr_of(0, seed);
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk);
            #1;
            if (k % n == h) begin
                ep = smp_of(k, seed);
                eo = ovr_of(k, seed);
                if (n > 1) ea = smp_of(k - h, seed);
            end
            // R1 R3 R5 R6 R7: primary word per mode
            chk({tag, " R1/R3/R5/R6/R7 prim"}, prim_out, ep);
            // R4 R5 R6: auxiliary word (frozen at mid-scale in single mode)
            chk({tag, " R4/R5/R6 aux"}, aux_out, ea);
            // R8: overrange follows primary sample
            chk({tag, " R8 ovr"}, ovr_out, eo);
            // R3 R5 R6: data-ready pattern
            chk({tag, " R3/R5/R6 drdy"}, drdy_out, int'((k % n) >= h));
            // R9 R10: sync falls at k = N/2
            chk({tag, " R9/R10 sync"}, sync_out, int'(k < h));
            @(negedge clk);
            smp_in = smp_of(k + 1, seed);
            ovr_in = ovr_of(k + 1, seed);
        end
    endtask

    initial begin
        run_mode(1'b0, 1'b0, 1, 40, 1, "single");
        run_mode(1'b0, 1'b1, 1, 12, 2, "single_sel_ignored");
        run_mode(1'b1, 1'b0, 2, 40, 3, "pair");
        run_mode(1'b1, 1'b1, 4, 48, 4, "decim");
        // R10: reset in the middle of a decimate period, then realign
        run_mode(1'b1, 1'b1, 4, 7, 5, "decim_part");
        run_mode(1'b1, 1'b1, 4, 20, 6, "R10 decim_restart");
        run_mode(1'b1, 1'b0, 2, 5, 7, "pair_part");
        run_mode(1'b1, 1'b0, 2, 16, 8, "R10 pair_restart");
        // R4: leave pair mode without reset; aux must then stay put
        begin
            logic [7:0] held;
            @(negedge clk);
            held = aux_out;
            split_en = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(posedge clk);
                #1;
                chk("R4 aux frozen after switch", aux_out, held);
                @(negedge clk);
                smp_in = smp_of(i, 9);
            end
            @(posedge clk);
            #1;
            chk("R3 prim follows after switch", prim_out, smp_of(9, 9));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule